// File: doc/BRIEF.md
# ADC Control and Result Register Block

This block sits between a simple 8-bit processor bus and an 8-bit successive-approximation converter. Software uses it to pick an input channel and start a conversion, to learn when a conversion has finished, and to fetch the 8-bit result. The same block also keeps the divider value that a clock prescaler elsewhere on the chip uses. The converter itself and the prescaler are outside this block.

A write to the control register starts a conversion on the written channel. When the converter reports that it is done, the result is captured. Depending on the interrupt-enable bit, the block then either sets a completion flag that software can poll, or raises an interrupt request. Reading the result or writing the control register acknowledges the completion.

Three registers are mapped at bus offsets 0 (control/status), 1 (result) and 2 (clock divider); offset 3 is unmapped. Read data is combinational: it is valid in the same cycle that `bus_rd` is high, and it is 0 whenever `bus_rd` is low. Every side effect of an access takes place at the clock edge that ends the access cycle.

Top module: `conv_ctrl_regs`

## Requirements
- R1: After reset, the control/status register reads 0x1F (channel field all ones, other bits 0), the result and divider registers read 0, and `irq` and `conv_start` are low.
- R2: With the interrupt enable (control bit 6) at 0, a `conv_done` pulse sets the completion flag, which reads back in bit 7 of offset 0, and `irq` stays low.
- R3: The completion flag clears at the edge of any write to offset 0 or any read of offset 1. Reads of offset 0 or offset 2 leave it unchanged.
- R4: With the interrupt enable at 1, bit 7 of offset 0 always reads 0, and a `conv_done` pulse sets `irq` high from the next cycle.
- R5: Once high, `irq` stays high until the edge of a read of offset 1 or a write of offset 0. Other accesses do not clear it.
- R6: If `conv_done` and a clearing access fall in the same cycle, the new completion wins: the flag (enable 0) or `irq` (enable 1) is set after that edge.
- R7: A write to offset 0 stores bits 6..0 (enable in bit 6, a spare control bit in bit 5, channel in bits 4..0) and ignores written bit 7. One cycle after the write, `conv_start` is high for one cycle and `chan_sel` shows the written channel.
- R8: A write to offset 0 whose channel field is 0x1F (converter off) updates `chan_sel` but produces no `conv_start` pulse.
- R9: On a `conv_done` pulse, `conv_result` is captured into the result register (offset 1). Bus writes to offset 1 have no effect on it.
- R10: The divider register at offset 2 is read/write, resets to 0, and drives `clk_div`.
- R11: A read of the unmapped offset 3 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, same cycle as `bus_rd`, 0 otherwise |
| conv_done | input | 1 | One-cycle completion pulse from the converter |
| conv_result | input | 8 | Conversion result, valid with `conv_done` |
| irq | output | 1 | Interrupt request |
| chan_sel | output | 5 | Selected input channel |
| conv_start | output | 1 | One-cycle conversion start pulse |
| clk_div | output | 8 | Divider value for the external prescaler |

## Verification
A wrong flag or interrupt state shows at the ports in the very next access: bit 7 of a status read, or the `irq` pin one cycle after the edge that set or cleared it. A wrong clear source only becomes visible after the access that should or should not have cleared it, so the bench interleaves reads of every offset between a completion and its acknowledgement. The same-cycle race between completion and clear is staged directly for both enable settings. A missing or extra start pulse shows on `conv_start` exactly one cycle after the control write.

// File: rtl/conv_regs_pkg.sv
package conv_regs_pkg;

    localparam int DATA_W   = 8;
    localparam int CHAN_W   = 5;
    localparam int ADDR_W   = 2;
    localparam int NUM_REGS = 3;
    localparam int CTRL_W   = CHAN_W + 2;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [CHAN_W-1:0] chan_t;

    // Register index doubles as bus offset
    localparam int IDX_CTRL = 0;
    localparam int IDX_RES  = 1;
    localparam int IDX_DIV  = 2;

    localparam addr_t OFS_CTRL = addr_t'(IDX_CTRL);
    localparam addr_t OFS_RES  = addr_t'(IDX_RES);
    localparam addr_t OFS_DIV  = addr_t'(IDX_DIV);

    localparam chan_t CHAN_OFF = '1;

    typedef struct packed {
        logic  ien;
        logic  spare;
        chan_t chan;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{ien: 1'b0, spare: 1'b0, chan: CHAN_OFF};

    typedef struct packed {
        logic [NUM_REGS-1:0] rd_sel;
        logic [NUM_REGS-1:0] wr_sel;
    } strobe_t;

    function automatic logic ack_access(strobe_t s);
        return s.wr_sel[IDX_CTRL] | s.rd_sel[IDX_RES];
    endfunction

    function automatic logic starts_conv(ctrl_t c);
        return c.chan != CHAN_OFF;
    endfunction

endpackage

// File: rtl/conv_bus_decode.sv
module conv_bus_decode
    import conv_regs_pkg::*;
(
    input  addr_t   addr,
    input  logic    rd,
    input  logic    wr,
    output strobe_t strb
);

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_sel
        logic hit;
        assign hit              = (addr == addr_t'(i));
        assign strb.rd_sel[i]   = rd & hit;
        assign strb.wr_sel[i]   = wr & hit;
    end

endmodule

// File: rtl/conv_hold_reg.sv
module conv_hold_reg #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= RST_VAL;
        end else if (ld) begin
            q <= d;
        end
    end

endmodule

// File: rtl/conv_status_unit.sv
module conv_status_unit
    import conv_regs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  strobe_t strb,
    input  ctrl_t   wr_ctrl,
    input  logic    done,
    output ctrl_t   ctrl_q,
    output logic    flag_q,
    output logic    irq_q,
    output logic    start_q
);

    logic ack;
    logic ctrl_wr;
    logic done_poll;
    logic done_int;

    assign ack       = ack_access(strb);
    assign ctrl_wr   = strb.wr_sel[IDX_CTRL];
    assign done_poll = done & ~ctrl_q.ien;
    assign done_int  = done &  ctrl_q.ien;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            flag_q  <= 1'b0;
            irq_q   <= 1'b0;
            start_q <= 1'b0;
        end else begin
            start_q <= ctrl_wr & starts_conv(wr_ctrl);
            if (ctrl_wr) begin
                ctrl_q <= wr_ctrl;
            end
            // new completion has priority over an acknowledge
            if (done_poll) begin
                flag_q <= 1'b1;
            end else if (ack) begin
                flag_q <= 1'b0;
            end
            if (done_int) begin
                irq_q <= 1'b1;
            end else if (ack) begin
                irq_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/conv_ctrl_regs.sv
module conv_ctrl_regs
    import conv_regs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_result,
    output logic              irq,
    output logic [CHAN_W-1:0] chan_sel,
    output logic              conv_start,
    output logic [DATA_W-1:0] clk_div
);

    strobe_t strb;
    ctrl_t   ctrl_q;
    ctrl_t   wr_ctrl;
    logic    flag_q;
    logic    irq_q;
    logic    ien_q;
    byte_t   res_q;
    byte_t   div_q;
    byte_t   ctrl_view;

    conv_bus_decode u_dec (
        .addr (bus_addr),
        .rd   (bus_rd),
        .wr   (bus_wr),
        .strb (strb)
    );

    assign wr_ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0]);

    conv_status_unit u_stat (
        .clk     (clk),
        .rst     (rst),
        .strb    (strb),
        .wr_ctrl (wr_ctrl),
        .done    (conv_done),
        .ctrl_q  (ctrl_q),
        .flag_q  (flag_q),
        .irq_q   (irq_q),
        .start_q (conv_start)
    );

    conv_hold_reg #(.W(DATA_W), .RST_VAL('0)) u_res (
        .clk (clk),
        .rst (rst),
        .ld  (conv_done),
        .d   (conv_result),
        .q   (res_q)
    );

    conv_hold_reg #(.W(DATA_W), .RST_VAL('0)) u_div (
        .clk (clk),
        .rst (rst),
        .ld  (strb.wr_sel[IDX_DIV]),
        .d   (bus_wdata),
        .q   (div_q)
    );

    assign ien_q     = ctrl_q.ien;
    assign ctrl_view = {flag_q & ~ien_q, ctrl_q};

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                OFS_CTRL: bus_rdata = ctrl_view;
                OFS_RES:  bus_rdata = res_q;
                OFS_DIV:  bus_rdata = div_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign irq      = irq_q;
    assign chan_sel = ctrl_q.chan;
    assign clk_div  = div_q;

endmodule

// File: rtl/conv_regs_chk.sv
module conv_regs_chk
    import conv_regs_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              conv_done,
    input logic [DATA_W-1:0] conv_result,
    input logic              irq,
    input logic [CHAN_W-1:0] chan_sel,
    input logic              conv_start,
    input logic              ien,
    input logic              flag,
    input logic [DATA_W-1:0] res
);

    logic ack_seen;
    assign ack_seen = (bus_wr && bus_addr == OFS_CTRL) || (bus_rd && bus_addr == OFS_RES);

    // R4
    flag_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_CTRL && ien) |-> !bus_rdata[DATA_W-1]);

    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_seen) |=> irq);

    // R6
    flag_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && !ien) |=> flag);

    // R6
    irq_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (conv_done && ien) |=> irq);

    // R7
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> $past(bus_wr && bus_addr == OFS_CTRL));

    // R8
    start_off_chk: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> chan_sel != CHAN_OFF);

    // R9
    result_capture_chk: assert property (@(posedge clk) disable iff (rst)
        conv_done |=> res == $past(conv_result));

    // R2
    poll_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (!irq && !(conv_done && ien)) |=> !irq);

endmodule

bind conv_ctrl_regs conv_regs_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_rd      (bus_rd),
    .bus_wr      (bus_wr),
    .bus_rdata   (bus_rdata),
    .conv_done   (conv_done),
    .conv_result (conv_result),
    .irq         (irq),
    .chan_sel    (chan_sel),
    .conv_start  (conv_start),
    .ien         (ien_q),
    .flag        (flag_q),
    .res         (res_q)
);

// File: tb/conv_ctrl_regs_bench.sv
module conv_ctrl_regs_bench;

    localparam int CLK_NS   = 20;
    localparam int WATCHDOG = 200000;

    localparam logic [1:0] OP_WR   = 2'd0;
    localparam logic [1:0] OP_RD   = 2'd1;
    localparam logic [1:0] OP_DONE = 2'd2;
    localparam logic [1:0] OP_IRQ  = 2'd3;

    localparam int NVEC = 33;

    // {op, addr, data, expected, requirement number}
    localparam logic [27:0] VEC [NVEC] = '{
        {OP_RD,   2'd0, 8'h00, 8'h1F, 8'd1},   // R1 control reset value
        {OP_RD,   2'd1, 8'h00, 8'h00, 8'd1},   // R1 result reset value
        {OP_RD,   2'd2, 8'h00, 8'h00, 8'd10},  // R10 divider reset value
        {OP_IRQ,  2'd0, 8'h00, 8'h00, 8'd1},   // R1 irq low
        {OP_WR,   2'd0, 8'h03, 8'h00, 8'd7},   // R7 poll mode, channel 3
        {OP_RD,   2'd0, 8'h00, 8'h03, 8'd7},
        {OP_DONE, 2'd0, 8'hA5, 8'h00, 8'd2},
        {OP_RD,   2'd0, 8'h00, 8'h83, 8'd2},   // R2 flag visible
        {OP_IRQ,  2'd0, 8'h00, 8'h00, 8'd2},   // R2 no irq in poll mode
        {OP_RD,   2'd0, 8'h00, 8'h83, 8'd3},   // R3 status read keeps flag
        {OP_RD,   2'd1, 8'h00, 8'hA5, 8'd9},   // R9 result, clears flag
        {OP_RD,   2'd0, 8'h00, 8'h03, 8'd3},   // R3 cleared by result read
        {OP_DONE, 2'd0, 8'h5A, 8'h00, 8'd2},
        {OP_WR,   2'd0, 8'h03, 8'h00, 8'd3},
        {OP_RD,   2'd0, 8'h00, 8'h03, 8'd3},   // R3 cleared by control write
        {OP_WR,   2'd1, 8'hFF, 8'h00, 8'd9},
        {OP_RD,   2'd1, 8'h00, 8'h5A, 8'd9},   // R9 write to result ignored
        {OP_WR,   2'd2, 8'h3C, 8'h00, 8'd10},
        {OP_RD,   2'd2, 8'h00, 8'h3C, 8'd10},  // R10 divider read/write
        {OP_RD,   2'd3, 8'h00, 8'h00, 8'd11},  // R11 unmapped offset
        {OP_WR,   2'd0, 8'h45, 8'h00, 8'd4},   // R4 interrupt mode, channel 5
        {OP_DONE, 2'd0, 8'h77, 8'h00, 8'd4},
        {OP_RD,   2'd0, 8'h00, 8'h45, 8'd4},   // R4 flag masked
        {OP_IRQ,  2'd0, 8'h00, 8'h01, 8'd4},   // R4 irq raised
        {OP_RD,   2'd2, 8'h00, 8'h3C, 8'd5},
        {OP_IRQ,  2'd0, 8'h00, 8'h01, 8'd5},   // R5 divider read keeps irq
        {OP_RD,   2'd1, 8'h00, 8'h77, 8'd9},
        {OP_IRQ,  2'd0, 8'h00, 8'h00, 8'd5},   // R5 result read clears irq
        {OP_DONE, 2'd0, 8'h11, 8'h00, 8'd5},
        {OP_IRQ,  2'd0, 8'h00, 8'h01, 8'd5},
        {OP_WR,   2'd0, 8'hC5, 8'h00, 8'd5},
        {OP_IRQ,  2'd0, 8'h00, 8'h00, 8'd5},   // R5 control write clears irq
        {OP_RD,   2'd0, 8'h00, 8'h45, 8'd7}    // R7 written bit 7 ignored
    };

    logic       clk = 1'b0;
    logic       rst;
    logic [1:0] bus_addr;
    logic       bus_rd;
    logic       bus_wr;
    logic [7:0] bus_wdata;
    logic [7:0] bus_rdata;
    logic       conv_done;
    logic [7:0] conv_result;
    logic       irq;
    logic [4:0] chan_sel;
    logic       conv_start;
    logic [7:0] clk_div;

    int  n_checks = 0;
    int  n_fail   = 0;
    bit  finished = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    conv_ctrl_regs u_conv_ctrl_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_addr    (bus_addr),
        .bus_rd      (bus_rd),
        .bus_wr      (bus_wr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .conv_done   (conv_done),
        .conv_result (conv_result),
        .irq         (irq),
        .chan_sel    (chan_sel),
        .conv_start  (conv_start),
        .clk_div     (clk_div)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        bus_rd      = 1'b0;
        bus_wr      = 1'b0;
        bus_addr    = 2'd0;
        bus_wdata   = 8'h00;
        conv_done   = 1'b0;
        conv_result = 8'h00;
    endtask

    // one bus or converter event per cycle, driven at the falling edge
    task automatic run_op(input logic [1:0] op, input logic [1:0] a,
                          input logic [7:0] d, input logic [7:0] e, input int r);
        @(negedge clk);
        idle_inputs();
        case (op)
            OP_WR:   begin bus_wr = 1'b1; bus_addr = a; bus_wdata = d; end
            OP_RD:   begin
                bus_rd = 1'b1; bus_addr = a;
                #1 check($sformatf("R%0d read offset %0d", r, a), bus_rdata, e);
            end
            OP_DONE: begin conv_done = 1'b1; conv_result = d; end
            default: check($sformatf("R%0d irq level", r), {7'd0, irq}, e);
        endcase
    endtask

    initial begin
        idle_inputs();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 start low after reset", {7'd0, conv_start}, 8'h00);
        check("R10 clk_div after reset", clk_div, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][27:26], VEC[i][25:24], VEC[i][23:16], VEC[i][15:8], int'(VEC[i][7:0]));
        end

        // R7 start pulse timing and channel
        run_op(OP_WR, 2'd0, 8'h09, 8'h00, 7);
        #1 check("R7 no start in write cycle", {7'd0, conv_start}, 8'h00);
        @(negedge clk);
        idle_inputs();
        check("R7 start one cycle after write", {7'd0, conv_start}, 8'h01);
        check("R7 chan_sel shows channel", {3'd0, chan_sel}, 8'h09);
        @(negedge clk);
        check("R7 start lasts one cycle", {7'd0, conv_start}, 8'h00);

        // R8 converter-off channel gives no start
        run_op(OP_WR, 2'd0, 8'h1F, 8'h00, 8);
        @(negedge clk);
        idle_inputs();
        check("R8 no start for channel 1F", {7'd0, conv_start}, 8'h00);
        check("R8 chan_sel updated", {3'd0, chan_sel}, 8'h1F);

        // R6 poll mode: completion and result read in one cycle
        run_op(OP_WR, 2'd0, 8'h02, 8'h00, 6);
        @(negedge clk);
        idle_inputs();
        conv_done = 1'b1; conv_result = 8'hC3;
        bus_rd = 1'b1; bus_addr = 2'd1;
        run_op(OP_RD, 2'd0, 8'h00, 8'h82, 6);   // R6 flag set wins
        run_op(OP_RD, 2'd1, 8'h00, 8'hC3, 6);   // R6 new result captured

        // R6 interrupt mode: completion and control write in one cycle
        run_op(OP_WR, 2'd0, 8'h42, 8'h00, 6);
        @(negedge clk);
        idle_inputs();
        conv_done = 1'b1; conv_result = 8'h3E;
        bus_wr = 1'b1; bus_addr = 2'd0; bus_wdata = 8'h42;
        run_op(OP_IRQ, 2'd0, 8'h00, 8'h01, 6);  // R6 irq set wins

        // R1 reset in the middle of activity
        run_op(OP_WR, 2'd2, 8'h99, 8'h00, 1);
        @(negedge clk);
        idle_inputs();
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 irq cleared by reset", {7'd0, irq}, 8'h00);
        check("R1 clk_div cleared by reset", clk_div, 8'h00);
        run_op(OP_RD, 2'd0, 8'h00, 8'h1F, 1);
        run_op(OP_RD, 2'd1, 8'h00, 8'h00, 1);
        @(negedge clk);
        idle_inputs();

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(CLK_NS * WATCHDOG);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule